// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host-side master for a 10-bit serial DAC that takes one 16-bit word per transfer. The word is carried on three lines: an active-low select line, a serial clock, and a data line. The host presents a 4-bit command nibble and a 10-bit output code, then strobes `start` for one cycle. The writer captures both fields and lowers the select line. It shifts out the command nibble, the code and two filler bits, most significant bit first, and the device samples each bit on the rising serial clock edge. Raising the select line at the end latches the word into the device.

Every interface interval is given as a minimum in nanoseconds, together with the system clock period. These minimums cover data setup, clock high time, clock low time, clock period, select-to-first-clock lead, last-clock-to-load and the select-high recovery. At elaboration each one is rounded up to a whole number of system-clock cycles, so no interval can come out shorter than its minimum. The host can issue frames back to back: `busy` drops as soon as the select-high recovery time has passed, and the next `start` is accepted then.

Top module: `dacw_ctrl`

## Requirements
- R1: While `rst` is high, `dac_csn` is 1, `sclk` is 0, `sdata` is 0, and both `busy` and `done` are 0.
- R2: Each frame has exactly 16 rising `sclk` edges. The bits sampled on those edges, in order, are ctrl[3] down to ctrl[0], then code[9] down to code[0], then two filler bits that are driven as 0.
- R3: Each `sclk` high phase and each low phase lasts at least 50 ns. Successive rising edges are at least 100 ns apart.
- R4: `sdata` changes only while `sclk` is low. It is stable for at least 60 ns before every rising `sclk` edge.
- R5: `dac_csn` falls only while `sclk` is low. The first rising `sclk` edge comes at least 30 ns after `dac_csn` falls.
- R6: `dac_csn` rises at least 50 ns after the 16th rising `sclk` edge of the frame.
- R7: `dac_csn` stays high for at least 100 ns between frames. Every rising `sclk` edge comes at least 30 ns after the most recent rise of `dac_csn`.
- R8: `busy` is 1 from the cycle after a start is accepted until the select-high recovery has ended. `done` is 1 for exactly one cycle, and that cycle is the one in which `dac_csn` rises.
- R9: A `start` that arrives while `busy` is 1 is ignored. `ctrl` and `code` are sampled only in the cycle a start is accepted, so later changes to them do not alter the frame in flight.
- R10: While `dac_csn` is high, `sclk` and `sdata` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to send a frame |
| ctrl | input | 4 | Command/address nibble, sent first |
| code | input | 10 | DAC output code, sent after the nibble |
| dac_csn | output | 1 | Active-low select; its rising edge loads the word |
| sclk | output | 1 | Serial clock, idles low |
| sdata | output | 1 | Serial data, sampled by the device on rising `sclk` |
| busy | output | 1 | Frame or select-high recovery in progress |
| done | output | 1 | One-cycle pulse when the word is loaded |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edge has passed. They also assume that `start`, `ctrl` and `code` change only between clock edges, and that `ctrl` and `code` need to be valid only in the cycle a start is accepted. The stimulus drives every input on the falling clock edge. It waits for `busy` to go low before each real request, so back-to-back frames meet the shortest allowed select-high gap. On random frames, and in a directed case during the recovery gap, it deliberately raises `start` and scrambles `ctrl` and `code` while `busy` is high, to show that these inputs are ignored during that time.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    localparam int CTRL_W  = 4;
    localparam int CODE_W  = 10;
    localparam int FILL_W  = 2;
    localparam int FRAME_W = CTRL_W + CODE_W + FILL_W;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CODE_W-1:0] code;
        logic [FILL_W-1:0] fill;
    } frame_t;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(max2(a, b), c);
    endfunction

endpackage

// File: rtl/dacw_timer.sv
module dacw_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic [W-1:0] cnt,
    output logic         zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/dacw_shreg.sv
module dacw_shreg
    import dacw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame,
    input  logic   shift,
    input  logic   clear,
    output logic   msb,
    output logic   last
);

    logic [FRAME_W-1:0] sr_q;
    logic [IDX_W-1:0]   idx_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= frame;
            idx_q <= '0;
        end else if (shift) begin
            sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign msb  = sr_q[FRAME_W-1];
    assign last = (idx_q == IDX_W'(FRAME_W - 1));

endmodule

// File: rtl/dacw_seq.sv
module dacw_seq
    import dacw_pkg::*;
#(
    parameter int LEAD_C = 3,
    parameter int HI_C   = 3,
    parameter int LO_C   = 3,
    parameter int TAIL_C = 3,
    parameter int GAP_C  = 5,
    localparam int MAXC  = max3(max3(LEAD_C, HI_C, LO_C), TAIL_C, GAP_C),
    localparam int CW    = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tmr_zero,
    input  logic [CW-1:0] tmr_cnt,
    input  logic          sh_last,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          sh_load,
    output logic          sh_shift,
    output logic          sh_clear,
    output logic          cs_n,
    output logic          sck,
    output logic          done,
    output logic          busy
);

    seq_state_e st_q, st_d;
    logic       cs_d, sck_d, done_d;

    always_comb begin
        st_d     = st_q;
        cs_d     = cs_n;
        sck_d    = sck;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_clear = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d     = ST_LEAD;
                    cs_d     = 1'b0;
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(LEAD_C - 1);
                end
            end
            ST_LEAD: begin
                if (tmr_zero) begin
                    st_d     = ST_HIGH;
                    sck_d    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HI_C - 1);
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    st_d     = ST_LOW;
                    sck_d    = 1'b0;
                    sh_shift = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(LO_C - 1);
                end
            end
            ST_LOW: begin
                if (tmr_zero) begin
                    sck_d    = 1'b1;
                    tmr_load = 1'b1;
                    if (sh_last) begin
                        st_d    = ST_TAIL;
                        tmr_val = CW'(TAIL_C - 1);
                    end else begin
                        st_d    = ST_HIGH;
                        tmr_val = CW'(HI_C - 1);
                    end
                end
            end
            ST_TAIL: begin
                // last high phase must still meet the minimum high time
                if (tmr_cnt <= CW'(TAIL_C - HI_C)) begin
                    sck_d = 1'b0;
                end
                if (tmr_zero) begin
                    st_d     = ST_GAP;
                    cs_d     = 1'b1;
                    sck_d    = 1'b0;
                    done_d   = 1'b1;
                    sh_clear = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(GAP_C - 1);
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            cs_n <= 1'b1;
            sck  <= 1'b0;
            done <= 1'b0;
        end else begin
            st_q <= st_d;
            cs_n <= cs_d;
            sck  <= sck_d;
            done <= done_d;
        end
    end

    assign busy = (st_q != ST_IDLE);

    AST_CS_FALL_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sck);  // R5

    AST_SCK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);  // R10

    AST_IDLE_IGNORES_NOTHING_ELSE: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> busy || $past(st_q == ST_GAP));  // R9

endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
    import dacw_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int SETUP_NS  = 60,
    parameter int HIGH_NS   = 50,
    parameter int LOW_NS    = 50,
    parameter int PERIOD_NS = 100,
    parameter int LEAD_NS   = 30,
    parameter int LOAD_NS   = 50,
    parameter int GAP_NS    = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [CODE_W-1:0] code,
    output logic              dac_csn,
    output logic              sclk,
    output logic              sdata,
    output logic              busy,
    output logic              done
);

    localparam int HI_C   = ns_to_cyc(HIGH_NS, CLK_NS);
    localparam int LO_C   = max3(ns_to_cyc(LOW_NS, CLK_NS),
                                 ns_to_cyc(SETUP_NS, CLK_NS),
                                 ns_to_cyc(PERIOD_NS, CLK_NS) - HI_C);
    localparam int LEAD_C = max2(ns_to_cyc(LEAD_NS, CLK_NS), ns_to_cyc(SETUP_NS, CLK_NS));
    localparam int TAIL_C = max2(ns_to_cyc(LOAD_NS, CLK_NS), HI_C);
    localparam int GAP_C  = ns_to_cyc(GAP_NS, CLK_NS);
    localparam int MAXC   = max3(max3(LEAD_C, HI_C, LO_C), TAIL_C, GAP_C);
    localparam int CW     = $clog2(MAXC + 1);

    frame_t        frame;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val, tmr_cnt;
    logic          sh_load, sh_shift, sh_clear, sh_last;

    assign frame = '{ctrl: ctrl, code: code, fill: '0};

    dacw_timer #(.W(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .cnt  (tmr_cnt),
        .zero (tmr_zero)
    );

    dacw_shreg u_shreg (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .frame (frame),
        .shift (sh_shift),
        .clear (sh_clear),
        .msb   (sdata),
        .last  (sh_last)
    );

    dacw_seq #(
        .LEAD_C (LEAD_C),
        .HI_C   (HI_C),
        .LO_C   (LO_C),
        .TAIL_C (TAIL_C),
        .GAP_C  (GAP_C)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tmr_zero (tmr_zero),
        .tmr_cnt  (tmr_cnt),
        .sh_last  (sh_last),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .sh_load  (sh_load),
        .sh_shift (sh_shift),
        .sh_clear (sh_clear),
        .cs_n     (dac_csn),
        .sck      (sclk),
        .done     (done),
        .busy     (busy)
    );

    // cycles the serial clock has been high, saturating; checker use only
    logic [15:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst || !sclk) begin
            hi_run <= '0;
        end else if (hi_run != 16'hFFFF) begin
            hi_run <= hi_run + 16'd1;
        end
    end

    AST_HIGH_PHASE_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_run >= 16'(HI_C)));  // R3

    AST_DATA_STABLE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdata));  // R4

    AST_DONE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_csn) |-> done);  // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R8

    AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !dac_csn |-> busy);  // R8

    AST_DATA_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        dac_csn |-> !sdata);  // R10

endmodule

// File: tb/dacw_ctrl_tb_top.sv
module dacw_ctrl_tb_top;

    localparam int TCLK = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] ctrl = '0;
    logic [9:0] code = '0;
    logic       dac_csn, sclk, sdata, busy, done;

    always #10 clk = ~clk;

    dacw_ctrl dut_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ctrl    (ctrl),
        .code    (code),
        .dac_csn (dac_csn),
        .sclk    (sclk),
        .sdata   (sdata),
        .busy    (busy),
        .done    (done)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_frame(input logic [3:0] c, input logic [9:0] d);
        return {c, d, 2'b00};
    endfunction

    logic [15:0] expq [0:255];
    int wr = 0;
    int rd = 0;
    int frames = 0;

    // ---------------- line monitor (samples on falling clock) ----------------
    int cyc = 0;
    logic pc = 1'b1, psck = 1'b0, psd = 1'b0, pdone = 1'b0;
    int t_csf = 0, t_csr = -1000, t_rise = -1000, t_fall = -1000, t_sd = -1000;
    logic [15:0] cap = '0;
    int nbits = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!psck && sclk) begin
                if (nbits == 0)
                    chk((cyc - t_csf) * TCLK >= 30, "R5 select-to-first-clock ns", (cyc - t_csf) * TCLK, 30);
                else begin
                    chk((cyc - t_fall) * TCLK >= 50, "R3 low phase ns", (cyc - t_fall) * TCLK, 50);
                    chk((cyc - t_rise) * TCLK >= 100, "R3 clock period ns", (cyc - t_rise) * TCLK, 100);
                end
                chk((cyc - t_sd) * TCLK >= 60, "R4 data setup ns", (cyc - t_sd) * TCLK, 60);
                chk((cyc - t_csr) * TCLK >= 30, "R7 select-high to clock ns", (cyc - t_csr) * TCLK, 30);
                chk(!dac_csn, "R10 clock edge only while selected", dac_csn, 0);
                cap = {cap[14:0], sdata};
                nbits++;
                t_rise = cyc;
            end
            if (psck && !sclk) begin
                chk((cyc - t_rise) * TCLK >= 50, "R3 high phase ns", (cyc - t_rise) * TCLK, 50);
                t_fall = cyc;
            end
            if (psd !== sdata) begin
                chk(!sclk, "R4 data moved while clock high", sclk, 0);
                t_sd = cyc;
            end
            if (pc && !dac_csn) begin
                chk(!sclk, "R5 select fell with clock high", sclk, 0);
                chk((cyc - t_csr) * TCLK >= 100, "R7 select-high gap ns", (cyc - t_csr) * TCLK, 100);
                t_csf = cyc;
                t_sd  = cyc;
                nbits = 0;
                cap   = '0;
            end
            if (!pc && dac_csn) begin
                chk((cyc - t_rise) * TCLK >= 50, "R6 last clock to load ns", (cyc - t_rise) * TCLK, 50);
                chk(done, "R8 done with load edge", done, 1);
                chk(nbits == 16, "R2 rising edges per frame", nbits, 16);
                if (rd < wr) begin
                    chk(cap == expq[rd], "R2 frame bits", cap, expq[rd]);
                    rd++;
                end else begin
                    chk(1'b0, "R9 frame without accepted start", cap, 0);
                end
                t_csr = cyc;
                frames++;
            end
            if (dac_csn)
                chk(!sclk && !sdata, "R10 lines low while deselected", {sclk, sdata}, 0);
            if (pdone)
                chk(!done, "R8 done wider than one cycle", done, 0);
            if (done)
                chk(!pc && dac_csn, "R8 done away from load edge", {pc, dac_csn}, 1);
        end
        psck  = sclk;
        psd   = sdata;
        pc    = dac_csn;
        pdone = done;
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [3:0] c, input logic [9:0] d, input bit disturb);
        while (busy) @(negedge clk);
        ctrl  = c;
        code  = d;
        start = 1'b1;
        expq[wr] = mk_frame(c, d);
        wr++;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R8 busy after accept", busy, 1);
        if (disturb) begin
            // R9: requests and new fields while busy must be ignored
            ctrl  = ~c;
            code  = ~d;
            start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
            repeat (40) @(negedge clk);
            start = 1'b1;
            ctrl  = 4'h9;
            code  = 10'h0F0;
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk(dac_csn == 1'b1, "R1 select high in reset", dac_csn, 1);
        chk(sclk == 1'b0, "R1 clock low in reset", sclk, 0);
        chk(sdata == 1'b0, "R1 data low in reset", sdata, 0);
        chk(!busy && !done, "R1 busy/done low in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);

        send(4'hF, 10'h3FF, 1'b0);
        send(4'h0, 10'h000, 1'b0);
        send(4'hA, 10'h155, 1'b1);
        send(4'h5, 10'h2AA, 1'b0);
        send(4'h8, 10'h001, 1'b0);
        send(4'h1, 10'h200, 1'b1);

        // R9 directed: start during the select-high recovery is dropped
        while (!done) @(negedge clk);
        start = 1'b1;
        ctrl  = 4'h3;
        code  = 10'h123;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(dac_csn && !busy, "R9 start during recovery ignored", {dac_csn, busy}, 2);

        for (int i = 0; i < 24; i++) begin
            logic [3:0] rc;
            logic [9:0] rv;
            rc = 4'($urandom());
            rv = 10'($urandom());
            send(rc, rv, ($urandom() % 3) == 0);
            repeat ($urandom() % 3) @(negedge clk);
        end

        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(frames == wr, "R9 frames sent vs accepted", frames, wr);
        chk(rd == wr, "R2 every accepted frame seen", rd, wr);
        chk(dac_csn && !sclk && !sdata, "R10 idle lines at end", {dac_csn, sclk, sdata}, 4);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        summary();
        $finish;
    end

endmodule